// File: doc/BRIEF.md
# Phase-Shared Register Port with Light-Pen Latch

This block lets a CPU and a video engine share one set of address pins, taking turns on the two phases of the system clock. While `phi2` is high the pins are inputs. During that phase the CPU can read or write one of sixteen 8-bit control registers, which sit in a fixed 16-byte window of its address space. While `phi2` is low the block drives the video engine's fetch address out on the same pins.

Four register slots are read-only. Two of them hold the beam position captured by a light pen. The other two pass through the current paddle readings. The light-pen input is asynchronous, so it goes through a two-flop synchronizer first. Its first falling edge in each frame latches the horizontal and vertical dot counters. Holding the pen low for a long stretch wipes the latched position.

Top module: `vbus_regif`

## Requirements
- R1: The registers answer only when `addr_in[14:4]` equals 0x100, so CPU addresses 0x1000 to 0x100F select registers 0 to 15 by `addr_in[3:0]`. Bit 15 of the address has no effect. An access outside the window leaves every register unchanged and returns 0 on `rdata`.
- R2: On each rising edge of `clk` with `phi2`=1, `rw`=0 and the window selected, `wdata` is stored in the addressed writable register. The new value shows on `ctrl_regs[8*i +: 8]` after that edge.
- R3: While `phi2`=1, `rw`=1 and the window is selected, `rdata` shows the addressed register in the same cycle. In every other case `rdata` is 0.
- R4: While `phi2`=0, `addr_oe`=1 and `addr_out` equals `fetch_addr`. In any cycle with `phi2`=1, `addr_oe`=0 and `addr_out`=0, with no clock delay.
- R5: CPU writes to registers 6, 7, 8 and 9 have no effect.
- R6: Register 8 reads as `pad_x` and register 9 reads as `pad_y`.
- R7: A falling edge on `pen_n` latches `beam_h` into register 6 and `beam_v` into register 7. The new values can be read by the fourth clock edge after the edge.
- R8: After a capture, further falling edges are ignored until `frame_start` has been pulsed.
- R9: If the synchronized `pen_n` stays low for `CLR_LEN` consecutive clocks, registers 6 and 7 clear to 0.
- R10: After reset, every writable register and both light-pen registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| phi2 | input | 1 | Phase flag: 1 = CPU phase, 0 = video phase |
| rw | input | 1 | 1 = read, 0 = write; valid while phi2 = 1 |
| addr_in | input | 16 | Address pins, sampled as input during the CPU phase |
| wdata | input | 8 | CPU write data |
| rdata | output | 8 | CPU read data, 0 when not read |
| addr_oe | output | 1 | Drive enable for the address pins |
| addr_out | output | AW | Address driven during the video phase |
| fetch_addr | input | AW | Video engine fetch address |
| beam_h | input | 8 | Current horizontal dot position |
| beam_v | input | 8 | Current vertical dot position |
| frame_start | input | 1 | One-cycle pulse at the start of each frame |
| pen_n | input | 1 | Asynchronous light-pen input, active low |
| pad_x | input | 8 | Paddle X reading |
| pad_y | input | 8 | Paddle Y reading |
| ctrl_regs | output | 128 | All sixteen registers, register i at bits 8i+7:8i |

## Verification
The properties assume that `phi2`, `rw`, `addr_in` and `wdata` change only away from the rising edge of `clk`, and that `rw` is high whenever `phi2` is low. The bench drives every input on the falling edge. Its random CPU cycles raise `phi2` for exactly one clock and return `rw` high on the way out. The pen pulses are short enough to stay under the clear threshold, except in the one case that tests the clear.

// File: rtl/vbus_regif.sv
module vbus_regif #(
  parameter int AW      = 14,
  parameter int CLR_LEN = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          phi2,
  input  logic          rw,
  input  logic [15:0]   addr_in,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  output logic          addr_oe,
  output logic [AW-1:0] addr_out,
  input  logic [AW-1:0] fetch_addr,
  input  logic [7:0]    beam_h,
  input  logic [7:0]    beam_v,
  input  logic          frame_start,
  input  logic          pen_n,
  input  logic [7:0]    pad_x,
  input  logic [7:0]    pad_y,
  output logic [127:0]  ctrl_regs
);
  localparam int CW = $clog2(CLR_LEN + 1);

  logic       sel, unused_a15;
  logic [3:0] idx;
  logic [7:0] view [16];
  logic [7:0] pen_h, pen_v;
  logic       s1, s2, s3, pen_done, fall;
  logic [CW-1:0] low_cnt;

  assign unused_a15 = addr_in[15];
  assign sel  = (addr_in[14:4] == 11'h100);
  assign idx  = addr_in[3:0];

  assign addr_oe  = ~phi2;
  assign addr_out = phi2 ? '0 : fetch_addr;
  assign rdata    = (phi2 && sel && rw) ? view[idx] : 8'h00;

  for (genvar i = 0; i < 16; i++) begin : g_reg
    if (i == 6) begin : g_ph
      assign view[i] = pen_h;
    end else if (i == 7) begin : g_pv
      assign view[i] = pen_v;
    end else if (i == 8) begin : g_px
      assign view[i] = pad_x;
    end else if (i == 9) begin : g_py
      assign view[i] = pad_y;
    end else begin : g_rw
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) q <= '0;
        else if (phi2 && sel && !rw && idx == 4'(i)) q <= wdata;
      assign view[i] = q;
    end
    assign ctrl_regs[8*i +: 8] = view[i];
  end

  assign fall = s3 & ~s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1; s2 <= 1'b1; s3 <= 1'b1;
      pen_done <= 1'b0;
      pen_h <= '0; pen_v <= '0;
      low_cnt <= '0;
    end else begin
      s1 <= pen_n; s2 <= s1; s3 <= s2;
      if (frame_start) pen_done <= 1'b0;
      if (fall && (!pen_done || frame_start)) begin
        pen_h <= beam_h;
        pen_v <= beam_v;
        pen_done <= 1'b1;
      end
      if (s2) low_cnt <= '0;
      else if (low_cnt != CW'(CLR_LEN)) low_cnt <= low_cnt + 1'b1;
      if (!s2 && low_cnt == CW'(CLR_LEN - 1)) begin
        pen_h <= '0;
        pen_v <= '0;
      end
    end
  end
endmodule

// File: rtl/vbus_regif_chk.sv
module vbus_regif_chk #(
  parameter int AW = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic          phi2,
  input logic          rw,
  input logic [15:0]   addr_in,
  input logic [7:0]    wdata,
  input logic [7:0]    rdata,
  input logic          addr_oe,
  input logic [AW-1:0] addr_out,
  input logic [AW-1:0] fetch_addr,
  input logic [127:0]  ctrl_regs
);
  logic       last_wr;
  logic [3:0] last_idx;
  logic [7:0] last_data;
  logic       hit, ro;

  assign hit = addr_in[14:12] == 3'b001 && addr_in[11:4] == 8'h00;
  assign ro  = addr_in[3:0] >= 4'd6 && addr_in[3:0] <= 4'd9;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      last_wr <= 1'b0; last_idx <= '0; last_data <= '0;
    end else begin
      last_wr   <= phi2 && hit && !rw && !ro;
      last_idx  <= addr_in[3:0];
      last_data <= wdata;
    end

  // R4
  cpu_phase_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phi2 |-> (!addr_oe && addr_out == '0));

  // R4
  video_phase_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !phi2 |-> (addr_oe && addr_out == fetch_addr));

  // R1
  outside_window_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phi2 && !hit) |-> rdata == 8'h00);

  // R3
  idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!phi2 || !rw) |-> rdata == 8'h00);

  // R2
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_wr |-> ctrl_regs[8*last_idx +: 8] == last_data);
endmodule

bind vbus_regif vbus_regif_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .phi2(phi2), .rw(rw), .addr_in(addr_in),
  .wdata(wdata), .rdata(rdata), .addr_oe(addr_oe), .addr_out(addr_out),
  .fetch_addr(fetch_addr), .ctrl_regs(ctrl_regs)
);

// File: tb/vbus_regif_bench.sv
module vbus_regif_bench;
  localparam int AW = 14;
  localparam int CLR_LEN = 16;

  logic clk = 0, rst_n = 0, phi2 = 0, rw = 1, frame_start = 0, pen_n = 1;
  logic [15:0] addr_in = '0;
  logic [7:0] wdata = '0, beam_h = '0, beam_v = '0, pad_x = '0, pad_y = '0;
  logic [AW-1:0] fetch_addr = '0;
  logic [7:0] rdata;
  logic addr_oe;
  logic [AW-1:0] addr_out;
  logic [127:0] ctrl_regs;

  int checks = 0, fails = 0;
  logic [7:0] model [16];
  logic [7:0] m_pen_h = 0, m_pen_v = 0;
  logic [7:0] rd;

  vbus_regif #(.AW(AW), .CLR_LEN(CLR_LEN)) u_vbus_regif (.*);

  always #10 clk = ~clk;

  function automatic bit in_window(logic [15:0] a);
    return a[14:4] == 11'h100;
  endfunction

  function automatic bit read_only(logic [3:0] i);
    return i >= 4'd6 && i <= 4'd9;
  endfunction

  function automatic logic [7:0] expect_reg(logic [3:0] i);
    case (i)
      4'd6: return m_pen_h;
      4'd7: return m_pen_v;
      4'd8: return pad_x;
      4'd9: return pad_y;
      default: return model[i];
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cpu_write(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    phi2 = 1; rw = 0; addr_in = a; wdata = d;
    @(negedge clk);
    phi2 = 0; rw = 1;
    if (in_window(a) && !read_only(a[3:0])) model[a[3:0]] = d;
  endtask

  task automatic cpu_read(logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    phi2 = 1; rw = 1; addr_in = a;
    #2 d = rdata;
    @(negedge clk);
    phi2 = 0;
  endtask

  task automatic pen_pulse(int low_cycles);
    @(negedge clk); pen_n = 0;
    repeat (low_cycles) @(negedge clk);
    pen_n = 1;
    repeat (5) @(negedge clk);
  endtask

  task automatic frame_pulse();
    @(negedge clk); frame_start = 1;
    @(negedge clk); frame_start = 0;
  endtask

  task automatic check_all(string req);
    for (int i = 0; i < 16; i++) check(req, ctrl_regs[8*i +: 8], expect_reg(4'(i)));
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) model[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_all("R10");

    // R4: phase-dependent drive of address pins
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      phi2 = 0; fetch_addr = AW'($urandom);
      #1 check("R4", {addr_oe, addr_out}, {1'b1, fetch_addr});
      phi2 = 1;
      #1 check("R4", {addr_oe, addr_out}, '0);
      phi2 = 0;
    end

    // R2/R1: directed edges of window, with and without A15
    cpu_write(16'h1000, 8'hA5);
    cpu_write(16'h900F, 8'h3C);
    check("R2", ctrl_regs[7:0], 8'hA5);
    check("R1", ctrl_regs[127:120], 8'h3C);
    cpu_write(16'h0FFF, 8'hEE);
    cpu_write(16'h1010, 8'hEE);
    check_all("R1");
    cpu_read(16'h1010, rd); check("R1", rd, 8'h00);
    cpu_read(16'h9000, rd); check("R3", rd, 8'hA5);

    // R5: writes to read-only slots
    pad_x = 8'h12; pad_y = 8'h34;
    for (int i = 6; i <= 9; i++) cpu_write(16'h1000 | 16'(i), 8'hFF);
    check_all("R5");

    // Random traffic
    for (int k = 0; k < 300; k++) begin
      logic [15:0] a;
      a = (($urandom % 4) != 0) ? {1'($urandom), 11'h100, 4'($urandom)} : 16'($urandom);
      pad_x = 8'($urandom); pad_y = 8'($urandom);
      if ($urandom % 2) cpu_write(a, 8'($urandom));
      else begin
        cpu_read(a, rd);
        if (in_window(a)) check((a[3:0] == 8 || a[3:0] == 9) ? "R6" : "R3", rd, expect_reg(a[3:0]));
        else check("R1", rd, 8'h00);
      end
    end
    check_all("R2");

    // R7: first edge in frame captures beam
    frame_pulse();
    beam_h = 8'h5A; beam_v = 8'h33;
    pen_pulse(2);
    m_pen_h = 8'h5A; m_pen_v = 8'h33;
    cpu_read(16'h1006, rd); check("R7", rd, 8'h5A);
    cpu_read(16'h1007, rd); check("R7", rd, 8'h33);

    // R8: second edge in same frame ignored
    beam_h = 8'h11; beam_v = 8'h22;
    pen_pulse(2);
    cpu_read(16'h1006, rd); check("R8", rd, 8'h5A);
    cpu_read(16'h1007, rd); check("R8", rd, 8'h33);

    frame_pulse();
    pen_pulse(2);
    m_pen_h = 8'h11; m_pen_v = 8'h22;
    cpu_read(16'h1006, rd); check("R8", rd, 8'h11);
    cpu_read(16'h1007, rd); check("R8", rd, 8'h22);

    // R9: long low clears pen registers
    pen_pulse(CLR_LEN + 20);
    m_pen_h = 0; m_pen_v = 0;
    cpu_read(16'h1006, rd); check("R9", rd, 8'h00);
    cpu_read(16'h1007, rd); check("R9", rd, 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule